// File: doc/BRIEF.md
# Linkable Dual Down-Counter Timer

This block holds two 16-bit down-counters, A and B. Each counter has its own reload value, mode byte and control/status byte, all reached through a simple byte-wide register port. A trigger copies the reload value into the counter. Each later count clock decrements it while its gate is open. When the counter reaches terminal count it raises an interrupt-pending flag. It then either reloads and keeps going (continuous) or halts (single-cycle). The shape of the counter's waveform is programmable: a short pulse, a one-shot level, or a square wave. An optional output pin shows this waveform.

Counter B can be chained to counter A. A's waveform can serve as B's gate, as B's trigger, or as B's count clock, which turns the pair into a 32-bit-style cascade or a delayed one-shot. Gate, trigger and count clock can each come from software bits or from external inputs. A freeze bit holds the readable count steady so that software can read the high and low bytes coherently. Reading the low byte releases the freeze.

Register reads return their data one clock after the read strobe. Writes take effect on the clock edge where the write strobe is sampled.

Top module: `dual_ctr_timer`

## Requirements
- R1: After synchronous reset every register reads 0, both counters are idle, and `tmr_out` and `tmr_irq` are 0.
- R2: Writing 1 to bit 1 of a control byte (A at 0x3, B at 0x4) triggers: the counter loads its reload value (A: 0x5 high/0x6 low, B: 0x7/0x8) and status bit 0 reads 1. Each count clock with the gate open then decrements the count. Reaching terminal count sets bit 5 (pending), which also drives `tmr_irq`. Writing 1 to control bit 5 clears it. Control bit 2 is the software gate, and the status byte reads {0,0,pending,0,freeze,gate,0,running}.
- R3: Mode bit 7 = 0 (single-cycle): at terminal count the counter stops with count 0 and the running bit cleared. Mode bit 7 = 1 (continuous): it reloads and keeps running.
- R4: Mode bits 1:0 pick the waveform. 0 gives a one-clock pulse in the clock after terminal count. 1 goes high at trigger and low at terminal count. 2 is cleared at trigger and toggles at every terminal count.
- R5: A trigger that arrives while the counter is running reloads it only if mode bit 2 (retrigger) is set; otherwise it is ignored.
- R6: The count advances only while the gate is open. The gate is control bit 2, ANDed with the `ext_gate` pin when mode bit 3 is set.
- R7: With mode bit 5 set, the counter decrements once per rising edge of its `ext_count` pin instead of every clock.
- R8: With mode bit 4 set, a rising edge on the counter's `ext_trig` pin acts as a trigger.
- R9: Config register 0x0 bit 2 enables A and bit 3 enables B. A disabled counter ignores triggers and holds its count.
- R10: Config bits 1:0 = 1: A's waveform level is ANDed into B's gate.
- R11: Config bits 1:0 = 2: each rising edge of A's waveform triggers B.
- R12: Config bits 1:0 = 3: each rising edge of A's waveform is B's count clock.
- R13: Writing 1 to control bit 3 freezes the count visible at the count bytes (A: 0x9 high/0xA low, B: 0xB/0xC) while counting goes on. Reading the low count byte clears the freeze. Control bit 1 always reads 0.
- R14: Mode bit 6 routes the waveform to `tmr_out`; when it is clear, `tmr_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the clock after `bus_rd` |
| ext_count | input | 2 | External count clocks (bit 0 = A, bit 1 = B) |
| ext_trig | input | 2 | External trigger inputs |
| ext_gate | input | 2 | External gate inputs |
| tmr_out | output | 2 | Waveform outputs when enabled |
| tmr_irq | output | 2 | Pending flags |

## Verification
On every cycle, the assertions check these properties:
- An accepted trigger always starts a count.
- A single-cycle counter always stops at zero.
- A disabled counter never moves.
- A frozen count view stays steady.
- The software-trigger bit never reads back as 1.
- Reset leaves both outputs low.

Some behaviours can only be shown by the bench's scenarios:
- Pulse, one-shot and square-wave output counts over a window.
- Retrigger with and without the retrigger enable.
- External gate, count and trigger.
- The three chaining modes, each with exact expected count values.

// File: rtl/ct_pkg.sv
package ct_pkg;

    typedef enum logic [1:0] {
        SHAPE_PULSE   = 2'd0,
        SHAPE_ONESHOT = 2'd1,
        SHAPE_SQUARE  = 2'd2,
        SHAPE_RSVD    = 2'd3
    } shape_e;

    typedef enum logic [1:0] {
        LNK_NONE = 2'd0,
        LNK_GATE = 2'd1,
        LNK_TRIG = 2'd2,
        LNK_CLK  = 2'd3
    } link_e;

    typedef struct packed {
        logic   cont;
        logic   ext_out;
        logic   ext_cnt;
        logic   ext_trg;
        logic   ext_gat;
        logic   retrig;
        shape_e shape;
    } mode_t;

    localparam int NUM_CTR = 2;
    localparam int ADR_CFG = 0;

    function automatic int adr_mode(input int i);
        return 1 + i;
    endfunction

    function automatic int adr_ctl(input int i);
        return 3 + i;
    endfunction

    function automatic int adr_tc_hi(input int i);
        return 5 + 2 * i;
    endfunction

    function automatic int adr_tc_lo(input int i);
        return 6 + 2 * i;
    endfunction

    function automatic int adr_cc_hi(input int i);
        return 9 + 2 * i;
    endfunction

    function automatic int adr_cc_lo(input int i);
        return 10 + 2 * i;
    endfunction

    function automatic logic [7:0] status_byte(input logic ip, input logic rcc,
                                               input logic gcb, input logic cip);
        return {2'b00, ip, 1'b0, rcc, gcb, 1'b0, cip};
    endfunction

endpackage

// File: rtl/ct_edge.sv
module ct_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    assign rise = din & ~prev_q;
endmodule

// File: rtl/ct_core.sv
module ct_core
    import ct_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  mode_t         mode,
    input  logic [CW-1:0] reload,
    input  logic          tick,
    input  logic          trig,
    input  logic          gate,
    input  logic          rcc_set,
    input  logic          rcc_clr,
    input  logic          ip_clr,
    output logic [CW-1:0] count,
    output logic [CW-1:0] view,
    output logic          rcc,
    output logic          cip,
    output logic          ip,
    output logic          wave
);
    logic [CW-1:0] count_d;
    logic [CW-1:0] latch_q;
    logic          fire;
    logic          step;
    logic          term;

    assign fire = en & trig & (~cip | mode.retrig);
    assign step = en & cip & gate & tick & ~fire;
    assign term = step & (count == CW'(1));

    always_comb begin
        count_d = count;
        if (fire)
            count_d = reload;
        else if (term)
            count_d = mode.cont ? reload : '0;
        else if (step)
            count_d = count - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            cip     <= 1'b0;
            ip      <= 1'b0;
            wave    <= 1'b0;
            rcc     <= 1'b0;
            latch_q <= '0;
        end else begin
            count <= count_d;

            if (fire)                 cip <= 1'b1;
            else if (term && !mode.cont) cip <= 1'b0;

            if (term)        ip <= 1'b1;
            else if (ip_clr) ip <= 1'b0;

            unique case (mode.shape)
                SHAPE_PULSE:   wave <= term;
                SHAPE_ONESHOT: begin
                    if (fire)      wave <= 1'b1;
                    else if (term) wave <= 1'b0;
                end
                SHAPE_SQUARE: begin
                    if (fire)      wave <= 1'b0;
                    else if (term) wave <= ~wave;
                end
                default:       wave <= 1'b0;
            endcase

            if (rcc_clr) begin
                rcc <= 1'b0;
            end else if (rcc_set && !rcc) begin
                rcc     <= 1'b1;
                latch_q <= count_d;
            end
        end
    end

    assign view = rcc ? latch_q : count;
endmodule

// File: rtl/dual_ctr_timer.sv
module dual_ctr_timer
    import ct_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        ext_count,
    input  logic [1:0]        ext_trig,
    input  logic [1:0]        ext_gate,
    output logic [1:0]        tmr_out,
    output logic [1:0]        tmr_irq
);
    localparam int CW = 2 * DATA_W;

    logic [1:0]                   en_q;
    link_e                        link_q;
    mode_t [NUM_CTR-1:0]          mode_q;
    logic  [NUM_CTR-1:0][CW-1:0]  tc_q;
    logic  [NUM_CTR-1:0]          gcb_q;

    logic  [NUM_CTR-1:0][CW-1:0]  cnt_live;
    logic  [NUM_CTR-1:0][CW-1:0]  cnt_view;
    logic  [NUM_CTR-1:0]          cip, rcc, ipv, wave;
    logic  [NUM_CTR-1:0]          tick_v, trig_v, gate_v;
    logic  [NUM_CTR-1:0]          sw_trig, rcc_set, rcc_clr, ip_clr;
    logic  [NUM_CTR-1:0]          cont_v;

    logic [4:0] edge_in, edge_rise;
    logic [1:0] cnt_rise, trg_rise;
    logic       a_rise;

    logic [DATA_W-1:0] rd_mux;

    assign edge_in  = {wave[0], ext_trig, ext_count};
    assign cnt_rise = edge_rise[1:0];
    assign trg_rise = edge_rise[3:2];
    assign a_rise   = edge_rise[4];

    ct_edge #(.W(5)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (edge_in),
        .rise (edge_rise)
    );

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            link_q <= LNK_NONE;
            mode_q <= '0;
            tc_q   <= '0;
            gcb_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(ADR_CFG)) begin
                link_q <= link_e'(bus_wdata[1:0]);
                en_q   <= bus_wdata[3:2];
            end
            for (int i = 0; i < NUM_CTR; i++) begin
                if (bus_addr == ADDR_W'(adr_mode(i)))
                    mode_q[i] <= mode_t'(bus_wdata[7:0]);
                if (bus_addr == ADDR_W'(adr_ctl(i)))
                    gcb_q[i] <= bus_wdata[2];
                if (bus_addr == ADDR_W'(adr_tc_hi(i)))
                    tc_q[i][CW-1:DATA_W] <= bus_wdata;
                if (bus_addr == ADDR_W'(adr_tc_lo(i)))
                    tc_q[i][DATA_W-1:0] <= bus_wdata;
            end
        end
    end

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic base_tick, base_gate, base_trig;
        logic ctl_wr;

        assign ctl_wr     = bus_wr & (bus_addr == ADDR_W'(adr_ctl(g)));
        assign sw_trig[g] = ctl_wr & bus_wdata[1];
        assign rcc_set[g] = ctl_wr & bus_wdata[3];
        assign ip_clr[g]  = ctl_wr & bus_wdata[5];
        assign rcc_clr[g] = bus_rd & (bus_addr == ADDR_W'(adr_cc_lo(g)));
        assign cont_v[g]  = mode_q[g].cont;

        assign base_tick = mode_q[g].ext_cnt ? cnt_rise[g] : 1'b1;
        assign base_gate = gcb_q[g] & (mode_q[g].ext_gat ? ext_gate[g] : 1'b1);
        assign base_trig = sw_trig[g] | (mode_q[g].ext_trg & trg_rise[g]);

        if (g == 1) begin : g_linked
            assign tick_v[g] = (link_q == LNK_CLK) ? a_rise : base_tick;
            assign gate_v[g] = base_gate & ((link_q == LNK_GATE) ? wave[0] : 1'b1);
            assign trig_v[g] = base_trig | ((link_q == LNK_TRIG) & a_rise);
        end else begin : g_free
            assign tick_v[g] = base_tick;
            assign gate_v[g] = base_gate;
            assign trig_v[g] = base_trig;
        end

        ct_core #(.CW(CW)) u_core (
            .clk     (clk),
            .rst     (rst),
            .en      (en_q[g]),
            .mode    (mode_q[g]),
            .reload  (tc_q[g]),
            .tick    (tick_v[g]),
            .trig    (trig_v[g]),
            .gate    (gate_v[g]),
            .rcc_set (rcc_set[g]),
            .rcc_clr (rcc_clr[g]),
            .ip_clr  (ip_clr[g]),
            .count   (cnt_live[g]),
            .view    (cnt_view[g]),
            .rcc     (rcc[g]),
            .cip     (cip[g]),
            .ip      (ipv[g]),
            .wave    (wave[g])
        );

        assign tmr_out[g] = mode_q[g].ext_out & wave[g];
        assign tmr_irq[g] = ipv[g];
    end

    // read path
    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(ADR_CFG))
            rd_mux = DATA_W'({en_q, link_q});
        for (int i = 0; i < NUM_CTR; i++) begin
            if (bus_addr == ADDR_W'(adr_mode(i)))  rd_mux = DATA_W'(mode_q[i]);
            if (bus_addr == ADDR_W'(adr_ctl(i)))
                rd_mux = DATA_W'(status_byte(ipv[i], rcc[i], gcb_q[i], cip[i]));
            if (bus_addr == ADDR_W'(adr_tc_hi(i))) rd_mux = tc_q[i][CW-1:DATA_W];
            if (bus_addr == ADDR_W'(adr_tc_lo(i))) rd_mux = tc_q[i][DATA_W-1:0];
            if (bus_addr == ADDR_W'(adr_cc_hi(i))) rd_mux = cnt_view[i][CW-1:DATA_W];
            if (bus_addr == ADDR_W'(adr_cc_lo(i))) rd_mux = cnt_view[i][DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/ct_chk.sv
module ct_chk
    import ct_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int CW     = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        bus_rd,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic [1:0]                  tmr_out,
    input logic [1:0]                  tmr_irq,
    input logic [1:0]                  en,
    input logic [1:0]                  cip,
    input logic [1:0]                  rcc,
    input logic [1:0]                  trig,
    input logic [1:0]                  cont,
    input logic [1:0][CW-1:0]          cnt_live,
    input logic [1:0][CW-1:0]          cnt_view
);
    logic ctl_rd;
    assign ctl_rd = bus_rd && (bus_addr == ADDR_W'(adr_ctl(0)) ||
                               bus_addr == ADDR_W'(adr_ctl(1)));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (tmr_out == 2'b00 && tmr_irq == 2'b00));

    assert_trig_reads_zero_R13: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_rd) |-> ((bus_rdata & DATA_W'(2)) == '0));

    for (genvar g = 0; g < 2; g++) begin : g_chk
        assert_trigger_starts_R2: assert property (@(posedge clk) disable iff (rst)
            (trig[g] && en[g] && !cip[g]) |=> cip[g]);

        assert_single_stops_zero_R3: assert property (@(posedge clk) disable iff (rst)
            (!cont[g] && $fell(cip[g])) |-> (cnt_live[g] == '0));

        assert_disabled_holds_R9: assert property (@(posedge clk) disable iff (rst)
            !en[g] |=> $stable(cnt_live[g]));

        assert_frozen_view_R13: assert property (@(posedge clk) disable iff (rst)
            (rcc[g] && $past(rcc[g])) |-> $stable(cnt_view[g]));
    end
endmodule

bind dual_ctr_timer ct_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CW     (2 * DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .tmr_out   (tmr_out),
    .tmr_irq   (tmr_irq),
    .en        (en_q),
    .cip       (cip),
    .rcc       (rcc),
    .trig      (trig_v),
    .cont      (cont_v),
    .cnt_live  (cnt_live),
    .cnt_view  (cnt_view)
);

// File: tb/dual_ctr_timer_tb.sv
module dual_ctr_timer_tb;
    localparam logic [3:0] A_CFG = 4'h0, A_MODE_A = 4'h1, A_MODE_B = 4'h2,
                           A_CTL_A = 4'h3, A_CTL_B = 4'h4,
                           A_TCH_A = 4'h5, A_TCL_A = 4'h6, A_TCH_B = 4'h7, A_TCL_B = 4'h8,
                           A_CCH_A = 4'h9, A_CCL_A = 4'hA, A_CCH_B = 4'hB, A_CCL_B = 4'hC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] ext_count = '0, ext_trig = '0, ext_gate = '0;
    logic [1:0] tmr_out, tmr_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_q = 1'b0;

    always #10 clk = ~clk;

    dual_ctr_timer u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_count(ext_count),
        .ext_trig(ext_trig), .ext_gate(ext_gate), .tmr_out(tmr_out), .tmr_irq(tmr_irq)
    );

    always @(posedge clk) rd_q <= bus_rd;

    // scoreboard monitor
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: read data %02h with no expected item", bus_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: read %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic count_high(input int idx, input int n, output int highs, output int pairs);
        logic prev = 1'b0;
        highs = 0; pairs = 0;
        for (int k = 0; k < n; k++) begin
            if (tmr_out[idx]) highs++;
            if (tmr_out[idx] && prev) pairs++;
            prev = tmr_out[idx];
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int h, p;
        idle(4);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        chk(tmr_out, 0, "R1 tmr_out");
        chk(tmr_irq, 0, "R1 tmr_irq");
        rd(A_CFG, 8'h00, "R1 config");
        rd(A_CTL_A, 8'h00, "R1 status A");
        rd(A_CCL_A, 8'h00, "R1 count A low");

        // R9 disabled counter B ignores trigger
        wr(A_CFG, 8'h04);
        wr(A_TCH_B, 8'h01); wr(A_TCL_B, 8'h00);
        wr(A_MODE_B, 8'hA0);
        wr(A_CTL_B, 8'h06);
        idle(3);
        rd(A_CTL_B, 8'h04, "R9 disabled no start");
        wr(A_CFG, 8'h0C);
        wr(A_CTL_B, 8'h06);
        rd(A_CTL_B, 8'h05, "R9 enabled starts");

        // R7 external count clock on B
        for (int k = 0; k < 5; k++) begin
            ext_count[1] = 1'b1; idle(1);
            ext_count[1] = 1'b0; idle(1);
        end
        rd(A_CCH_B, 8'h00, "R7 count high");
        rd(A_CCL_B, 8'hFB, "R7 count low");

        // R8 external trigger reloads B (retrigger on, gate off)
        wr(A_CTL_B, 8'h00);
        wr(A_MODE_B, 8'h94);
        wr(A_TCH_B, 8'h02); wr(A_TCL_B, 8'h00);
        ext_trig[1] = 1'b1; idle(1); ext_trig[1] = 1'b0;
        idle(2);
        rd(A_CCH_B, 8'h02, "R8 reload high");
        rd(A_CCL_B, 8'h00, "R8 reload low");

        // R6 external gate
        wr(A_MODE_B, 8'h8C);
        wr(A_CTL_B, 8'h04);
        idle(5);
        rd(A_CCL_B, 8'h00, "R6 ext gate closed holds");
        ext_gate[1] = 1'b1; idle(3); ext_gate[1] = 1'b0;
        idle(2);
        rd(A_CCH_B, 8'h01, "R6 three steps high");
        rd(A_CCL_B, 8'hFD, "R6 three steps low");

        // R2 R4 R14 one-shot single-cycle on A
        wr(A_MODE_A, 8'h41);
        wr(A_TCH_A, 8'h00); wr(A_TCL_A, 8'h05);
        wr(A_CTL_A, 8'h06);
        chk(tmr_out[0], 1, "R4 one-shot high after trigger");
        rd(A_CTL_A, 8'h05, "R2 running after trigger");
        idle(10);
        chk(tmr_out[0], 0, "R4 one-shot low after terminal");
        chk(tmr_irq[0], 1, "R2 irq at terminal");
        rd(A_CTL_A, 8'h24, "R3 single-cycle stopped, pending set");
        rd(A_CCL_A, 8'h00, "R3 stopped at zero");
        wr(A_CTL_A, 8'h24);
        rd(A_CTL_A, 8'h04, "R2 pending cleared");
        chk(tmr_irq[0], 0, "R2 irq cleared");

        // R6 software gate holds count
        wr(A_MODE_A, 8'h80);
        wr(A_TCH_A, 8'h10); wr(A_TCL_A, 8'h00);
        wr(A_CTL_A, 8'h06);
        wr(A_CTL_A, 8'h00);
        rd(A_CCH_A, 8'h0F, "R6 gate off high");
        rd(A_CCL_A, 8'hFF, "R6 gate off low");
        idle(5);
        rd(A_CCL_A, 8'hFF, "R6 still held");

        // R13 freeze view
        wr(A_CTL_A, 8'h04);
        wr(A_CTL_A, 8'h0C);
        idle(20);
        rd(A_CTL_A, 8'h0D, "R13 freeze bit set");
        rd(A_CCH_A, 8'h0F, "R13 frozen high");
        rd(A_CCL_A, 8'hFE, "R13 frozen low");
        rd(A_CTL_A, 8'h05, "R13 low read releases");

        // R5 retrigger
        wr(A_CTL_A, 8'h00);
        wr(A_CTL_A, 8'h02);
        rd(A_CCH_A, 8'h0F, "R5 trigger ignored without retrigger");
        wr(A_MODE_A, 8'h84);
        wr(A_CTL_A, 8'h02);
        rd(A_CCH_A, 8'h10, "R5 retrigger reload high");
        rd(A_CCL_A, 8'h00, "R5 retrigger reload low");

        // R4 pulse, R3 continuous
        wr(A_TCH_A, 8'h00); wr(A_TCL_A, 8'h03);
        wr(A_MODE_A, 8'hC4);
        wr(A_CTL_A, 8'h06);
        count_high(0, 30, h, p);
        chk(h, 9, "R4 pulse count");
        chk(p, 0, "R4 pulse one clock wide");
        rd(A_CTL_A, 8'h25, "R3 continuous keeps running");

        // R4 square wave
        wr(A_MODE_A, 8'hC6);
        wr(A_CTL_A, 8'h06);
        count_high(0, 30, h, p);
        chk(h, 15, "R4 square high cycles");

        // R14 output disabled
        wr(A_MODE_A, 8'h86);
        count_high(0, 12, h, p);
        chk(h, 0, "R14 output masked");

        // prepare A as one-shot, tc 8
        wr(A_CTL_A, 8'h00);
        wr(A_MODE_A, 8'h05);
        wr(A_TCH_A, 8'h00); wr(A_TCL_A, 8'h08);
        wr(A_CTL_A, 8'h06);
        idle(20);

        // R10 link gate
        wr(A_CFG, 8'h0D);
        wr(A_MODE_B, 8'h84);
        wr(A_CTL_B, 8'h06);
        idle(5);
        rd(A_CCH_B, 8'h02, "R10 gated closed high");
        rd(A_CCL_B, 8'h00, "R10 gated closed low");
        wr(A_CTL_A, 8'h06);
        idle(20);
        rd(A_CCH_B, 8'h01, "R10 eight steps high");
        rd(A_CCL_B, 8'hF8, "R10 eight steps low");

        // R11 link trigger
        wr(A_CFG, 8'h0E);
        wr(A_CTL_B, 8'h00);
        wr(A_TCH_B, 8'h03); wr(A_TCL_B, 8'h00);
        wr(A_CTL_A, 8'h06);
        idle(20);
        rd(A_CCH_B, 8'h03, "R11 linked reload high");
        rd(A_CCL_B, 8'h00, "R11 linked reload low");

        // R12 link count clock
        wr(A_CFG, 8'h0F);
        wr(A_MODE_B, 8'h80);
        wr(A_CTL_B, 8'h04);
        for (int k = 0; k < 3; k++) begin
            wr(A_CTL_A, 8'h06);
            idle(15);
        end
        rd(A_CCH_B, 8'h02, "R12 three edges high");
        rd(A_CCL_B, 8'hFD, "R12 three edges low");

        idle(3);
        chk(exp_q.size(), 0, "scoreboard drained");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule